// File: doc/BRIEF.md
# Banked Nibble RAM Address Generator

This block produces the 12-bit physical address for a 4-bit controller's nibble-wide data memory. It holds three registers: a 4-bit bank select and the two 4-bit pointer halves H and L. The block forms the address from these registers or from the second instruction byte. The caller picks one of three addressing schemes: pointer-indirect, 8-bit direct, or a 16-nibble zero page that always sits at the bottom of memory. A fourth mode code is reserved.

The memory map is not uniform. Bank 0 is short, and holds only offsets 00h to F3h. Banks 1 to 9 each hold a full 256 nibbles. Bank codes above 9 fold onto bank 0. An address that falls in the missing top of bank 0 drops the valid flag. The same flag also gates the write strobe towards the RAM and forces read data to zero. A pointer-increment input steps the H:L pair as one 8-bit counter for store-and-advance sequences.

Top module: `nram_addr_gen`

## Requirements
- R1: After reset the bank register, H and L are all zero. `bank_wr` loads `bank_din` into the bank register on a clock edge. `ptr_wr` loads `h_din` and `l_din` into H and L on a clock edge.
- R2: With `mode` = 2'b00 (pointer-indirect), `addr` = {effective bank, H, L}. H forms bits 7:4 of the offset and L forms bits 3:0.
- R3: With `mode` = 2'b01 (direct), `addr` = {effective bank, `operand[7:0]`}.
- R4: With `mode` = 2'b10 (zero page), `addr` = {8'h00, `operand[3:0]`}. The bank register and `operand[7:4]` have no effect in this mode.
- R5: Bank codes 0 to 9 select banks 0 to 9, which appear in `addr[11:8]`. Codes 10 to 15 give effective bank 0.
- R6: `addr_ok` is low when the effective bank is 0 and the offset is F4h to FFh. It is high for every other address in modes 00, 01 and 10.
- R7: `ram_we` equals `mem_we` when `addr_ok` is high and is 0 otherwise. `rdata` equals `ram_rdata` when `addr_ok` is high and is 4'h0 otherwise.
- R8: When `ptr_inc` is high and `ptr_wr` is low, H:L becomes H:L + 1 on the clock edge. L carries into H when L wraps from Fh, FFh wraps to 00h, and the bank register does not change.
- R9: When `ptr_wr` and `ptr_inc` are high in the same cycle, the load wins.
- R10: With `mode` = 2'b11 (reserved), `addr` = 12'h000 and `addr_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_wr | input | 1 | Load strobe for the bank register |
| bank_din | input | 4 | New bank code |
| ptr_wr | input | 1 | Load strobe for H and L |
| h_din | input | 4 | New H value |
| l_din | input | 4 | New L value |
| ptr_inc | input | 1 | Step H:L by one |
| mode | input | 2 | 00 indirect, 01 direct, 10 zero page, 11 reserved |
| operand | input | 8 | Second instruction byte |
| mem_we | input | 1 | Requested write strobe |
| ram_rdata | input | 4 | Data returned by the RAM |
| addr | output | 12 | Physical nibble address |
| addr_ok | output | 1 | Address lies in populated memory |
| ram_we | output | 1 | Gated write strobe to the RAM |
| rdata | output | 4 | Gated read data |
| h_q | output | 4 | Current H |
| l_q | output | 4 | Current L |

## Verification
A vector table drives each mode across several bank codes. It uses low, mid and top banks, plus aliased codes 10, 12 and 15, so that a wrong bank fold shows up as a wrong high nibble. Offsets F3h and F4h in bank 0 bracket the edge of the short bank. FFh in bank 9 confirms that full banks never drop the flag. Zero-page vectors use non-zero banks and a set upper operand nibble, which exposes any leak of either into the address. Directed cases cover the L-to-H carry, the FFh wrap with the bank unchanged, load-over-increment priority, and the gating of writes and read data.

// File: rtl/nram_addr_gen.sv
module nram_addr_gen #(
  parameter int NW        = 4,
  parameter int NBANKS    = 10,
  parameter int BANK0_TOP = 8'hF3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bank_wr,
  input  logic [NW-1:0]   bank_din,
  input  logic            ptr_wr,
  input  logic [NW-1:0]   h_din,
  input  logic [NW-1:0]   l_din,
  input  logic            ptr_inc,
  input  logic [1:0]      mode,
  input  logic [2*NW-1:0] operand,
  input  logic            mem_we,
  input  logic [NW-1:0]   ram_rdata,
  output logic [3*NW-1:0] addr,
  output logic            addr_ok,
  output logic            ram_we,
  output logic [NW-1:0]   rdata,
  output logic [NW-1:0]   h_q,
  output logic [NW-1:0]   l_q
);
  localparam int OW = 2*NW;
  localparam logic [1:0] M_IND = 2'b00, M_DIR = 2'b01, M_ZP = 2'b10;

  logic [NW-1:0] bank_q;
  logic [NW-1:0] eff_bank;
  logic [OW-1:0] offs;
  logic          short_hole;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      h_q    <= '0;
      l_q    <= '0;
    end else begin
      if (bank_wr) bank_q <= bank_din;
      if (ptr_wr) begin
        h_q <= h_din;
        l_q <= l_din;
      end else if (ptr_inc) begin
        {h_q, l_q} <= {h_q, l_q} + 1'b1;
      end
    end
  end

  assign eff_bank = (int'(bank_q) < NBANKS) ? bank_q : '0;
  assign offs     = (mode == M_IND) ? {h_q, l_q} : operand;

  always_comb begin
    case (mode)
      M_IND, M_DIR: addr = {eff_bank, offs};
      M_ZP:         addr = {{(OW){1'b0}}, operand[NW-1:0]};
      default:      addr = '0;
    endcase
  end

  assign short_hole = (eff_bank == '0) && (int'(offs) > BANK0_TOP);
  assign addr_ok    = (mode == M_ZP) || ((mode != 2'b11) && !short_hole);
  assign ram_we     = mem_we & addr_ok;
  assign rdata      = addr_ok ? ram_rdata : '0;

  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (h_q == '0 && l_q == '0));

  p_zp_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_ZP |-> (addr[3*NW-1:NW] == '0 && addr_ok));

  p_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ZP && int'(addr[3*NW-1:OW]) >= NBANKS) |-> 1'b0);

  p_hole_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ZP && addr[3*NW-1:OW] == '0 && int'(addr[OW-1:0]) > BANK0_TOP) |-> !addr_ok);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> (!ram_we && rdata == '0));

  p_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_wr) |=> ({h_q, l_q} == $past({h_q, l_q}) + 1'b1));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (h_q == $past(h_din) && l_q == $past(l_din)));

  p_resv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> (addr == '0 && !addr_ok));
endmodule

// File: tb/test_nram_addr_gen.sv
module test_nram_addr_gen;
  logic clk = 0, rst_n = 0;
  logic bank_wr = 0, ptr_wr = 0, ptr_inc = 0, mem_we = 0;
  logic [3:0] bank_din = 0, h_din = 0, l_din = 0, ram_rdata = 0;
  logic [1:0] mode = 0;
  logic [7:0] operand = 0;
  logic [11:0] addr;
  logic addr_ok, ram_we;
  logic [3:0] rdata, h_q, l_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nram_addr_gen i_nram_addr_gen (
    .clk, .rst_n, .bank_wr, .bank_din, .ptr_wr, .h_din, .l_din, .ptr_inc,
    .mode, .operand, .mem_we, .ram_rdata, .addr, .addr_ok, .ram_we, .rdata, .h_q, .l_q);

  // {bank, h, l, mode, operand, exp_addr, exp_ok}
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {4'h1, 4'h4, 4'h3, 2'd0, 8'h00, 12'h143, 1'b1},  // R2
    {4'h0, 4'h3, 4'h2, 2'd0, 8'h00, 12'h032, 1'b1},  // R2
    {4'h9, 4'hF, 4'hF, 2'd0, 8'h00, 12'h9FF, 1'b1},  // R2 R6
    {4'h0, 4'hF, 4'h3, 2'd0, 8'h00, 12'h0F3, 1'b1},  // R6
    {4'h0, 4'hF, 4'h4, 2'd0, 8'h00, 12'h0F4, 1'b0},  // R6
    {4'h0, 4'h0, 4'h0, 2'd1, 8'h23, 12'h023, 1'b1},  // R3
    {4'h5, 4'h0, 4'h0, 2'd1, 8'hA7, 12'h5A7, 1'b1},  // R3
    {4'h0, 4'h1, 4'h1, 2'd1, 8'hFF, 12'h0FF, 1'b0},  // R3 R6
    {4'hA, 4'h0, 4'h0, 2'd1, 8'h10, 12'h010, 1'b1},  // R5
    {4'hF, 4'hF, 4'h5, 2'd0, 8'h00, 12'h0F5, 1'b0},  // R5 R6
    {4'hC, 4'h2, 4'h8, 2'd0, 8'h00, 12'h028, 1'b1},  // R5
    {4'h7, 4'h0, 4'h0, 2'd2, 8'h3C, 12'h00C, 1'b1},  // R4
    {4'h0, 4'h0, 4'h0, 2'd2, 8'hF5, 12'h005, 1'b1},  // R4
    {4'hC, 4'hF, 4'hF, 2'd2, 8'hFF, 12'h00F, 1'b1},  // R4
    {4'h3, 4'h1, 4'h1, 2'd3, 8'h55, 12'h000, 1'b0},  // R10
    {4'h8, 4'h0, 4'h0, 2'd3, 8'h00, 12'h000, 1'b0}   // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] b, input logic [3:0] h, input logic [3:0] l);
    @(negedge clk);
    bank_wr = 1; bank_din = b; ptr_wr = 1; h_din = h; l_din = l;
    @(negedge clk);
    bank_wr = 0; ptr_wr = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 addr after reset", {20'h0, addr}, 32'h000);
    check("R1 ok after reset", {31'h0, addr_ok}, 32'h1);
    check("R1 hl after reset", {24'h0, h_q, l_q}, 32'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i][34:31], VEC[i][30:27], VEC[i][26:23]);
      mode = VEC[i][22:21]; operand = VEC[i][20:13];
      #1;
      check($sformatf("R2-6/R10 vec%0d addr", i), {20'h0, addr}, {20'h0, VEC[i][12:1]});
      check($sformatf("R6/R10 vec%0d ok", i), {31'h0, addr_ok}, {31'h0, VEC[i][0]});
    end

    // R7 gating
    mode = 2'd0; load(4'h0, 4'hF, 4'hA);
    mem_we = 1; ram_rdata = 4'hA; #1;
    check("R7 we blocked", {31'h0, ram_we}, 32'h0);
    check("R7 rdata zero", {28'h0, rdata}, 32'h0);
    load(4'h2, 4'hF, 4'hA); #1;
    check("R7 we passed", {31'h0, ram_we}, 32'h1);
    check("R7 rdata passed", {28'h0, rdata}, 32'hA);
    mem_we = 0;

    // R8 increment with carry
    load(4'h4, 4'h2, 4'hF);
    ptr_inc = 1; @(negedge clk); ptr_inc = 0;
    check("R8 carry into H", {24'h0, h_q, l_q}, 32'h30);
    load(4'h4, 4'hF, 4'hF);
    ptr_inc = 1; @(negedge clk); ptr_inc = 0;
    check("R8 wrap FF", {24'h0, h_q, l_q}, 32'h00);
    check("R8 bank kept", {20'h0, addr}, 32'h400);
    ptr_inc = 1; @(negedge clk); @(negedge clk); ptr_inc = 0;
    check("R8 two steps", {24'h0, h_q, l_q}, 32'h02);

    // R9 load over increment
    ptr_wr = 1; ptr_inc = 1; h_din = 4'h1; l_din = 4'h1;
    @(negedge clk); ptr_wr = 0; ptr_inc = 0;
    check("R9 load wins", {24'h0, h_q, l_q}, 32'h11);

    // R1 bank held without strobe
    bank_din = 4'h9; @(negedge clk);
    check("R1 bank held", {20'h0, addr}, 32'h411);

    // R4 bank ignored in zero page
    mode = 2'd2; operand = 8'hE7; #1;
    check("R4 bank ignored", {20'h0, addr}, 32'h007);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule